// File: doc/BRIEF.md
# Tagged Translation Lookaside Buffer

This block holds eight recent translations from virtual page number to physical page number and consults them on every memory access. Each slot stores the page numbers, a process tag, separate two-bit rights for kernel and user mode, and reference, modify and cacheable flags. A request matches a slot only when the page number and the current process tag both agree. A context switch therefore only changes the `cur_tag` input, and no flush is needed.

A lookup is resolved in one cycle and its outcome is registered. There are three outcomes:

- A permitted hit returns the physical address.
- A hit whose access the slot forbids returns a protection fault.
- A miss asks an external refill agent to supply the entry.

The refill agent walks the tables and then presents the entry on the refill port. The block places it in one of three slots, in this order of preference:

1. The slot already holding that page and tag, so no duplicate is created.
2. The lowest free slot.
3. A victim chosen by a seven-bit tree pseudo-LRU.

Three one-cycle maintenance commands keep the buffer consistent with the page tables. They take priority over a refill issued in the same cycle.

Top module: `tagged_tlb`

## Requirements
- R1: While reset is held and after it is released, `rs_valid` is 0 and every slot is empty, so the first lookup of any page misses; `rs_valid` is 1 exactly in the cycle after a cycle with `lk_valid` high.
- R2: A lookup hits only in a valid slot whose page number equals `lk_vpn` and whose tag equals `cur_tag`. A permitted hit reports `rs_hit`=1 one cycle later, with `rs_paddr` = {stored physical page, `lk_off`} and `rs_cacheable` equal to the slot's cacheable flag.
- R3: A lookup with no matching valid slot reports `rs_miss`=1 with `rs_paddr`=0; exactly one of hit, miss and fault is set whenever `rs_valid` is 1.
- R4: The rights field encodes 00 = no access, 01 = read only, 10 or 11 = read and write. The kernel field applies when `lk_kernel`=1, and the user field otherwise. A load needs a non-zero field and a store needs bit 1 of the field. A forbidden hit reports `rs_fault`=1 with `rs_paddr`=0 and leaves the slot's flags unchanged.
- R5: On a hit, `rs_ref` and `rs_mod` report the slot's reference and modify flags as they were before the access. A permitted hit sets the reference flag. A permitted store also sets the modify flag. A refill clears both. On a miss or a fault, `rs_ref` and `rs_mod` are 0.
- R6: A refill (`rf_valid`=1 with `mt_cmd`=00) writes the slot that already holds the same page and tag if there is one. Otherwise it writes the lowest-numbered free slot, and failing that the pseudo-LRU victim.
- R7: Pseudo-LRU is a tree of bits p0..p6. The victim index bit 2 is p0, bit 1 is p1 or p2 (chosen by bit 2), and bit 0 is p(3+2*bit2+bit1). Every hit and every accepted refill sets the three bits on the touched slot's path to point away from it. After the eight slots are filled in order 0..7 and slot 0 is then hit, the next victim is slot 4.
- R8: `mt_cmd`=01 invalidates the slot holding `mt_vpn` under tag `mt_tag` and leaves other slots untouched.
- R9: `mt_cmd`=10 invalidates every slot with tag `mt_tag` and keeps the slots of other tags.
- R10: `mt_cmd`=11 invalidates every slot.
- R11: A refill presented in the same cycle as any non-zero `mt_cmd` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_tag | input | 8 | Process tag of the running context |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number of the lookup |
| lk_off | input | 12 | Page offset, passed through |
| lk_store | input | 1 | 1 = store, 0 = load |
| lk_kernel | input | 1 | 1 = kernel-mode access |
| rs_valid | output | 1 | Registered result present |
| rs_hit | output | 1 | Permitted hit |
| rs_miss | output | 1 | No matching slot; refill wanted |
| rs_fault | output | 1 | Hit with forbidden access |
| rs_paddr | output | 32 | Physical address on a hit, else 0 |
| rs_cacheable | output | 1 | Cacheable flag of the hit slot |
| rs_ref | output | 1 | Reference flag before this access |
| rs_mod | output | 1 | Modify flag before this access |
| rf_valid | input | 1 | Refill entry present |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_tag | input | 8 | Refill process tag |
| rf_ppn | input | 20 | Refill physical page number |
| rf_krights | input | 2 | Refill kernel rights |
| rf_urights | input | 2 | Refill user rights |
| rf_cacheable | input | 1 | Refill cacheable flag |
| mt_cmd | input | 2 | 00 none, 01 drop page, 10 drop tag, 11 drop all |
| mt_vpn | input | 20 | Page number for command 01 |
| mt_tag | input | 8 | Tag for commands 01 and 10 |

## Verification
Maintenance and refill can fall in the same cycle. This is provoked by asserting a drop-all command together with a refill of a fresh page; a following lookup of that page must miss.

A lookup can also coincide with a permitted store on a slot whose flags it updates. The flag-reporting outputs are therefore judged over a run of successive accesses to one page: load, forbidden store, permitted store, and load again. Each access must report the flags that the previous accesses left behind.

// File: rtl/tagged_tlb.sv
module tagged_tlb #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int TAG_W = 8,
  parameter int OFF_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TAG_W-1:0]       cur_tag,
  input  logic                   lk_valid,
  input  logic [VPN_W-1:0]       lk_vpn,
  input  logic [OFF_W-1:0]       lk_off,
  input  logic                   lk_store,
  input  logic                   lk_kernel,
  output logic                   rs_valid,
  output logic                   rs_hit,
  output logic                   rs_miss,
  output logic                   rs_fault,
  output logic [PPN_W+OFF_W-1:0] rs_paddr,
  output logic                   rs_cacheable,
  output logic                   rs_ref,
  output logic                   rs_mod,
  input  logic                   rf_valid,
  input  logic [VPN_W-1:0]       rf_vpn,
  input  logic [TAG_W-1:0]       rf_tag,
  input  logic [PPN_W-1:0]       rf_ppn,
  input  logic [1:0]             rf_krights,
  input  logic [1:0]             rf_urights,
  input  logic                   rf_cacheable,
  input  logic [1:0]             mt_cmd,
  input  logic [VPN_W-1:0]       mt_vpn,
  input  logic [TAG_W-1:0]       mt_tag
);
  localparam int N  = 8;
  localparam int IW = $clog2(N);

  logic [N-1:0]     vld, refd, modd, cach;
  logic [VPN_W-1:0] vpn_q [N];
  logic [TAG_W-1:0] tag_q [N];
  logic [PPN_W-1:0] ppn_q [N];
  logic [1:0]       kr_q  [N];
  logic [1:0]       ur_q  [N];
  logic [6:0]       plru, plru_n;

  logic          hit, rmatch, fany, allow, rf_take;
  logic [IW-1:0] hidx, ridx, fidx, vic, slot;
  logic [1:0]    rights;

  function automatic logic [6:0] touch(logic [6:0] p, logic [IW-1:0] e);
    p[0] = ~e[2];
    if (e[2]) p[2] = ~e[1];
    else      p[1] = ~e[1];
    p[3 + 2*int'(e[2]) + int'(e[1])] = ~e[0];
    return p;
  endfunction

  always_comb begin
    hit = 1'b0; hidx = '0; rmatch = 1'b0; ridx = '0; fany = 1'b0; fidx = '0;
    for (int i = 0; i < N; i++) begin
      if (vld[i] && vpn_q[i] == lk_vpn && tag_q[i] == cur_tag) begin
        hit = 1'b1; hidx = IW'(i);
      end
      if (vld[i] && vpn_q[i] == rf_vpn && tag_q[i] == rf_tag) begin
        rmatch = 1'b1; ridx = IW'(i);
      end
    end
    for (int i = N-1; i >= 0; i--)
      if (!vld[i]) begin fany = 1'b1; fidx = IW'(i); end
  end

  assign vic[2] = plru[0];
  assign vic[1] = vic[2] ? plru[2] : plru[1];
  assign vic[0] = plru[3 + 2*int'(vic[2]) + int'(vic[1])];
  assign slot   = rmatch ? ridx : (fany ? fidx : vic);

  assign rights  = lk_kernel ? kr_q[hidx] : ur_q[hidx];
  assign allow   = lk_store ? rights[1] : |rights;
  assign rf_take = rf_valid && mt_cmd == 2'b00;

  always_comb begin
    plru_n = plru;
    if (lk_valid && hit) plru_n = touch(plru_n, hidx);
    if (rf_take)         plru_n = touch(plru_n, slot);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0; refd <= '0; modd <= '0; cach <= '0; plru <= '0;
      rs_valid <= 1'b0; rs_hit <= 1'b0; rs_miss <= 1'b0; rs_fault <= 1'b0;
      rs_paddr <= '0; rs_cacheable <= 1'b0; rs_ref <= 1'b0; rs_mod <= 1'b0;
    end else begin
      rs_valid     <= lk_valid;
      rs_hit       <= lk_valid && hit && allow;
      rs_fault     <= lk_valid && hit && !allow;
      rs_miss      <= lk_valid && !hit;
      rs_paddr     <= (lk_valid && hit && allow) ? {ppn_q[hidx], lk_off} : '0;
      rs_cacheable <= lk_valid && hit && allow && cach[hidx];
      rs_ref       <= lk_valid && hit && allow && refd[hidx];
      rs_mod       <= lk_valid && hit && allow && modd[hidx];
      plru         <= plru_n;
      if (lk_valid && hit && allow) begin
        refd[hidx] <= 1'b1;
        if (lk_store) modd[hidx] <= 1'b1;
      end
      if (mt_cmd != 2'b00) begin
        for (int i = 0; i < N; i++) begin
          case (mt_cmd)
            2'b01:   if (vpn_q[i] == mt_vpn && tag_q[i] == mt_tag) vld[i] <= 1'b0;
            2'b10:   if (tag_q[i] == mt_tag) vld[i] <= 1'b0;
            default: vld[i] <= 1'b0;
          endcase
        end
      end else if (rf_take) begin
        vld[slot]   <= 1'b1;
        vpn_q[slot] <= rf_vpn;
        tag_q[slot] <= rf_tag;
        ppn_q[slot] <= rf_ppn;
        kr_q[slot]  <= rf_krights;
        ur_q[slot]  <= rf_urights;
        cach[slot]  <= rf_cacheable;
        refd[slot]  <= 1'b0;
        modd[slot]  <= 1'b0;
      end
    end
  end

  a_r1_result_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid);
  a_r1_no_result_unasked: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid);
  a_r3_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> $onehot({rs_hit, rs_miss, rs_fault}));
  a_r3_no_address_unless_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_hit |-> (rs_paddr == '0 && !rs_ref && !rs_mod));
  a_r2_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (!rs_hit || rs_paddr[OFF_W-1:0] == $past(lk_off)));
  a_r10_drop_all_empties: assert property (@(posedge clk) disable iff (!rst_n)
    mt_cmd == 2'b11 |=> vld == '0);
  a_r11_refill_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (mt_cmd != 2'b00 && rf_valid) |=> (vld & ~$past(vld)) == '0);
endmodule

// File: tb/test_tagged_tlb.sv
module test_tagged_tlb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cur_tag = '0;
  logic        lk_valid = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic [11:0] lk_off = '0;
  logic        lk_store = 1'b0, lk_kernel = 1'b0;
  logic        rs_valid, rs_hit, rs_miss, rs_fault, rs_cacheable, rs_ref, rs_mod;
  logic [31:0] rs_paddr;
  logic        rf_valid = 1'b0;
  logic [19:0] rf_vpn = '0, rf_ppn = '0;
  logic [7:0]  rf_tag = '0;
  logic [1:0]  rf_krights = '0, rf_urights = '0;
  logic        rf_cacheable = 1'b0;
  logic [1:0]  mt_cmd = '0;
  logic [19:0] mt_vpn = '0;
  logic [7:0]  mt_tag = '0;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tagged_tlb i_tagged_tlb (.*);

  typedef struct packed {
    logic [1:0]  kind;   // 0 lookup, 1 refill, 2 maintenance
    logic [19:0] vpn;
    logic [7:0]  tag;
    logic        st;
    logic        kern;
    logic [1:0]  kr;
    logic [1:0]  ur;
    logic [19:0] ppn;    // refill data, or expected page on a hit
    logic [1:0]  mcmd;
    logic [1:0]  expo;   // 0 miss, 1 hit, 2 fault
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 20'h12345, 8'd5, 1'b0, 1'b0, 2'd0, 2'd0, 20'h00000, 2'd0, 2'd0}, // R3 empty
    '{2'd1, 20'h12345, 8'd5, 1'b0, 1'b0, 2'd2, 2'd1, 20'hABCDE, 2'd0, 2'd0},
    '{2'd0, 20'h12345, 8'd5, 1'b0, 1'b0, 2'd0, 2'd0, 20'hABCDE, 2'd0, 2'd1}, // R2 user load
    '{2'd0, 20'h12345, 8'd6, 1'b0, 1'b0, 2'd0, 2'd0, 20'h00000, 2'd0, 2'd0}, // R2 tag mismatch
    '{2'd0, 20'h12345, 8'd5, 1'b1, 1'b0, 2'd0, 2'd0, 20'h00000, 2'd0, 2'd2}, // R4 user store
    '{2'd0, 20'h12345, 8'd5, 1'b1, 1'b1, 2'd0, 2'd0, 20'hABCDE, 2'd0, 2'd1}, // R4 kernel store
    '{2'd1, 20'h22222, 8'd6, 1'b0, 1'b0, 2'd0, 2'd0, 20'h11111, 2'd0, 2'd0},
    '{2'd0, 20'h22222, 8'd6, 1'b0, 1'b1, 2'd0, 2'd0, 20'h00000, 2'd0, 2'd2}, // R4 no rights
    '{2'd1, 20'h12345, 8'd5, 1'b0, 1'b0, 2'd2, 2'd2, 20'h54321, 2'd0, 2'd0},
    '{2'd0, 20'h12345, 8'd5, 1'b1, 1'b0, 2'd0, 2'd0, 20'h54321, 2'd0, 2'd1}, // R6 in place
    '{2'd2, 20'h12345, 8'd5, 1'b0, 1'b0, 2'd0, 2'd0, 20'h00000, 2'd1, 2'd0},
    '{2'd0, 20'h12345, 8'd5, 1'b0, 1'b0, 2'd0, 2'd0, 20'h00000, 2'd0, 2'd0}, // R8 dropped
    '{2'd0, 20'h22222, 8'd6, 1'b0, 1'b1, 2'd0, 2'd0, 20'h00000, 2'd0, 2'd2}  // R8 other kept
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic look(input logic [19:0] vpn, input logic [7:0] tag,
                      input logic st, input logic kern);
    lk_valid = 1'b1; lk_vpn = vpn; cur_tag = tag; lk_store = st; lk_kernel = kern;
    lk_off = 12'hABC;
    tick();
    lk_valid = 1'b0;
  endtask

  task automatic put_rf(input logic [19:0] vpn, input logic [7:0] tag, input logic [19:0] ppn,
                        input logic [1:0] kr, input logic [1:0] ur, input logic ca);
    rf_valid = 1'b1; rf_vpn = vpn; rf_tag = tag; rf_ppn = ppn;
    rf_krights = kr; rf_urights = ur; rf_cacheable = ca;
  endtask

  task automatic refill(input logic [19:0] vpn, input logic [7:0] tag, input logic [19:0] ppn,
                        input logic [1:0] kr, input logic [1:0] ur, input logic ca);
    put_rf(vpn, tag, ppn, kr, ur, ca);
    tick();
    rf_valid = 1'b0;
  endtask

  task automatic maint(input logic [1:0] cmd, input logic [19:0] vpn, input logic [7:0] tag);
    mt_cmd = cmd; mt_vpn = vpn; mt_tag = tag;
    tick();
    mt_cmd = 2'b00;
  endtask

  task automatic outcome(input string req, input logic [1:0] expo, input logic [19:0] ppn);
    logic [2:0] got, want;
    got  = {rs_fault, rs_hit, rs_miss};
    want = (expo == 2'd0) ? 3'b001 : (expo == 2'd1) ? 3'b010 : 3'b100;
    chk(req, {rs_valid, got}, {1'b1, want});
    chk(req, rs_paddr, (expo == 2'd1) ? {ppn, 12'hABC} : 32'h0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(); tick();
    chk("R1 valid in reset", rs_valid, 1'b0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    look(20'h00042, 8'd1, 1'b0, 1'b1);
    outcome("R1 empty after reset", 2'd0, 20'h0);
    tick();
    chk("R1 valid only after request", rs_valid, 1'b0);

    for (int k = 0; k < NV; k++) begin
      case (VEC[k].kind)
        2'd1: refill(VEC[k].vpn, VEC[k].tag, VEC[k].ppn, VEC[k].kr, VEC[k].ur, 1'b0);
        2'd2: maint(VEC[k].mcmd, VEC[k].vpn, VEC[k].tag);
        default: begin
          look(VEC[k].vpn, VEC[k].tag, VEC[k].st, VEC[k].kern);
          outcome($sformatf("R2/R3/R4 vector %0d", k), VEC[k].expo, VEC[k].ppn);
        end
      endcase
    end

    // R5: flag history, R2 cacheable
    do_reset();
    refill(20'h00300, 8'd1, 20'h00777, 2'd2, 2'd1, 1'b1);
    look(20'h00300, 8'd1, 1'b0, 1'b0);
    outcome("R5 first load", 2'd1, 20'h00777);
    chk("R2 cacheable", rs_cacheable, 1'b1);
    chk("R5 first load flags", {rs_ref, rs_mod}, 2'b00);
    look(20'h00300, 8'd1, 1'b1, 1'b0);
    outcome("R4 user store on read only", 2'd2, 20'h0);
    chk("R5 fault flags zero", {rs_ref, rs_mod}, 2'b00);
    look(20'h00300, 8'd1, 1'b1, 1'b1);
    chk("R5 store sees ref set, mod clear", {rs_hit, rs_ref, rs_mod}, 3'b110);
    look(20'h00300, 8'd1, 1'b0, 1'b0);
    chk("R5 load sees mod set", {rs_hit, rs_ref, rs_mod}, 3'b111);
    refill(20'h00300, 8'd1, 20'h00888, 2'd2, 2'd1, 1'b0);
    look(20'h00300, 8'd1, 1'b0, 1'b0);
    outcome("R6 refill replaces in place", 2'd1, 20'h00888);
    chk("R5 refill clears flags", {rs_ref, rs_mod, rs_cacheable}, 3'b000);

    // R9 and R10
    refill(20'h00500, 8'd3, 20'h00005, 2'd1, 2'd1, 1'b0);
    refill(20'h00501, 8'd4, 20'h00006, 2'd1, 2'd1, 1'b0);
    maint(2'b10, 20'h0, 8'd3);
    look(20'h00500, 8'd3, 1'b0, 1'b0);
    outcome("R9 tag dropped", 2'd0, 20'h0);
    look(20'h00501, 8'd4, 1'b0, 1'b0);
    outcome("R9 other tag kept", 2'd1, 20'h00006);
    maint(2'b11, 20'h0, 8'd0);
    look(20'h00501, 8'd4, 1'b0, 1'b0);
    outcome("R10 all dropped", 2'd0, 20'h0);

    // R11: maintenance and refill in one cycle
    put_rf(20'h00400, 8'd2, 20'h00444, 2'd1, 2'd1, 1'b0);
    maint(2'b11, 20'h0, 8'd0);
    rf_valid = 1'b0;
    look(20'h00400, 8'd2, 1'b0, 1'b0);
    outcome("R11 refill dropped", 2'd0, 20'h0);

    // R6/R7: fill in order, hit slot 0, next victim is slot 4
    do_reset();
    for (int i = 0; i < 8; i++)
      refill(20'h00100 + 20'(i), 8'd9, 20'h00A00 + 20'(i), 2'd1, 2'd1, 1'b0);
    look(20'h00100, 8'd9, 1'b0, 1'b0);
    outcome("R6 lowest free slots filled", 2'd1, 20'h00A00);
    refill(20'h00108, 8'd9, 20'h00A08, 2'd1, 2'd1, 1'b0);
    look(20'h00104, 8'd9, 1'b0, 1'b0);
    outcome("R7 slot 4 evicted", 2'd0, 20'h0);
    look(20'h00101, 8'd9, 1'b0, 1'b0);
    outcome("R7 slot 1 kept", 2'd1, 20'h00A01);
    look(20'h00108, 8'd9, 1'b0, 1'b0);
    outcome("R7 new entry present", 2'd1, 20'h00A08);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule